// File: doc/BRIEF.md
# Biphase Serial Word Receiver

This block recovers single words from a 1 Mb/s half-duplex command/response avionics bus that uses Manchester II biphase coding. The line arrives as an already-sliced logic level, sampled once per clock at 16 samples per bit cell. The receive path has its own state and does not depend on any transmit logic. The block finds the 3 bit-time sync header, which deliberately breaks the biphase rules. It reports whether the header marks a command/status word or a data word. It then recovers 16 information bits and one parity bit.

Each finished word raises exactly one of two single-cycle interrupts. A clean word raises the "word" interrupt. A word with a coding or parity fault raises the "error" interrupt, and a two-bit status field shows which fault occurred. For command/status words, the top five bits are compared against a bank of programmable terminal addresses, each with its own enable. The all-ones address is always accepted as broadcast. This lets one interface serve several terminals.

Top module: `mbus_word_rx`

## Requirements
- R1: After reset, irq_word, irq_err, rx_word, rx_cmd_sync, err_status and addr_hit are all zero.
- R2: A sync is accepted when the line holds one level for 22 to 26 samples, measured from the previous line transition, and then changes level. A high first half reports rx_cmd_sync=1 (command/status). A low first half reports rx_cmd_sync=0 (data).
- R3: A header whose first half lies outside 22..26 samples produces no interrupt.
- R4: Bit cells are 16 samples long. The first cell starts 24 samples after the mid-sync transition. Each cell is sampled at its 4th and 12th sample. High-then-low decodes as 1 and low-then-high as 0. The first 16 cells fill rx_word MSB first (bit 15 first), and the 17th cell is parity.
- R5: A cell whose two samples are equal sets err_status[1] (coding error) for that word.
- R6: Parity is odd over the 16 data bits plus the parity bit. An even total sets err_status[0].
- R7: A fault-free word gives a one-cycle irq_word pulse in the cycle after the last sample of the parity cell. At that point rx_word holds the data and err_status is 0.
- R8: A faulty word gives a one-cycle irq_err pulse instead of irq_word. rx_word and err_status are still updated.
- R9: addr_hit is 1 for a fault-free command/status word whose bits 15:11 equal an enabled entry of term_addr (entry i in bits 5i+4:5i).
- R10: Address 31 in bits 15:11 of a fault-free command/status word sets addr_hit even with every entry disabled.
- R11: addr_hit is 0 for data words, faulty words, and words that match only disabled entries.
- R12: irq_word and irq_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16 per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Sliced serial line level |
| term_addr | input | 20 | Four 5-bit terminal addresses |
| term_en | input | 4 | Per-entry enable |
| irq_word | output | 1 | Clean word received pulse |
| irq_err | output | 1 | Faulty word received pulse |
| rx_word | output | 16 | Last decoded word |
| rx_cmd_sync | output | 1 | Last sync was command/status type |
| err_status | output | 2 | Bit 1 coding error, bit 0 parity error |
| addr_hit | output | 1 | Last word addressed to this interface |

## Verification
Some properties are checked on every cycle. The two interrupts are checked to be exclusive and single-cycle. The status field must agree with whichever interrupt fired. An address hit may only appear alongside a clean command/status word, and a broadcast address must always produce a hit. Bit decoding is checked to start only out of a confirmed sync half. Other behaviours can only be shown by the bench's scenarios. These are the decoded values themselves, the sync window edges at 22 and 26 samples, the rejection of stretched headers, the effect of one faulty cell, and matching against random address sets.

// File: rtl/mbus_rx_pkg.sv
package mbus_rx_pkg;
    localparam int WORD_W = 16;
    localparam int ERR_CODE = 1;
    localparam int ERR_PAR  = 0;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_BITS  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/mbus_addr_match.sv
module mbus_addr_match #(
    parameter int N_ADDR = 4,
    parameter int AW     = 5
) (
    input  logic [AW-1:0]        field,
    input  logic [N_ADDR*AW-1:0] cfg,
    input  logic [N_ADDR-1:0]    en,
    output logic                 hit
);
    logic [N_ADDR-1:0] lane_hit;

    for (genvar i = 0; i < N_ADDR; i++) begin : g_lane
        assign lane_hit[i] = en[i] && (cfg[i*AW +: AW] == field);
    end

    assign hit = (|lane_hit) || (field == {AW{1'b1}});
endmodule

// File: rtl/mbus_rx_core.sv
module mbus_rx_core
    import mbus_rx_pkg::*;
#(
    parameter int SPB = 16,
    parameter int TOL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    output logic              fin,
    output logic [WORD_W-1:0] fin_word,
    output logic              fin_cmd,
    output logic              fin_code_err,
    output logic              fin_par_err
);
    localparam int HALF   = 3 * SPB / 2;
    localparam int RUNMAX = HALF + TOL + 1;
    localparam int RUNW   = $clog2(RUNMAX + 1);
    localparam int CW     = $clog2(HALF);
    localparam int BW     = $clog2(WORD_W + 1);

    localparam logic [RUNW-1:0] RUN_LO  = RUNW'(HALF - TOL);
    localparam logic [RUNW-1:0] RUN_HI  = RUNW'(HALF + TOL);
    localparam logic [RUNW-1:0] RUN_SAT = RUNW'(RUNMAX);
    localparam logic [CW-1:0]   C_MID   = CW'(HALF / 2);
    localparam logic [CW-1:0]   C_END   = CW'(HALF - 1);
    localparam logic [CW-1:0]   P_EARLY = CW'(SPB / 4);
    localparam logic [CW-1:0]   P_LATE  = CW'(3 * SPB / 4);
    localparam logic [CW-1:0]   P_LAST  = CW'(SPB - 1);
    localparam logic [BW-1:0]   B_LAST  = BW'(WORD_W);

    typedef struct packed {
        rx_state_e         st;
        logic              prev;
        logic [RUNW-1:0]   run;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bidx;
        logic              cmd;
        logic              a;
        logic              b;
        logic              code;
        logic [WORD_W-1:0] sh;
    } core_reg_t;

    core_reg_t r_q, r_d;
    logic      edge_seen;

    always_comb begin
        r_d          = r_q;
        fin          = 1'b0;
        edge_seen    = (rx_in != r_q.prev);
        r_d.prev     = rx_in;
        r_d.run      = edge_seen ? RUNW'(1)
                     : ((r_q.run == RUN_SAT) ? r_q.run : r_q.run + RUNW'(1));
        fin_word     = r_q.sh;
        fin_cmd      = r_q.cmd;
        fin_code_err = r_q.code | (r_q.a == r_q.b);
        fin_par_err  = ~(^{r_q.sh, r_q.a});

        unique case (r_q.st)
            ST_HUNT: begin
                if (edge_seen && r_q.run >= RUN_LO && r_q.run <= RUN_HI) begin
                    r_d.st  = ST_SYNC2;
                    r_d.cmd = r_q.prev;
                    r_d.cnt = CW'(1);
                end
            end
            ST_SYNC2: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == C_MID && rx_in == r_q.cmd) begin
                    r_d.st = ST_HUNT;
                end else if (r_q.cnt == C_END) begin
                    r_d.st   = ST_BITS;
                    r_d.cnt  = '0;
                    r_d.bidx = '0;
                    r_d.code = 1'b0;
                end
            end
            ST_BITS: begin
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == P_EARLY) r_d.a = rx_in;
                if (r_q.cnt == P_LATE)  r_d.b = rx_in;
                if (r_q.cnt == P_LAST) begin
                    r_d.cnt  = '0;
                    r_d.bidx = r_q.bidx + BW'(1);
                    r_d.code = r_q.code | (r_q.a == r_q.b);
                    if (r_q.bidx == B_LAST) begin
                        r_d.st = ST_HUNT;
                        fin    = 1'b1;
                    end else begin
                        r_d.sh = {r_q.sh[WORD_W-2:0], r_q.a};
                    end
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R4: decoding only begins straight out of the second sync half
    a_r4_bits_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BITS && $past(r_q.st) != ST_BITS) |-> $past(r_q.st) == ST_SYNC2);

    // R2: the second half is only entered after an in-window first half
    a_r2_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SYNC2 && $past(r_q.st) == ST_HUNT)
        |-> ($past(r_q.run) >= RUN_LO && $past(r_q.run) <= RUN_HI));
endmodule

// File: rtl/mbus_word_rx.sv
module mbus_word_rx
    import mbus_rx_pkg::*;
#(
    parameter int SPB      = 16,
    parameter int SYNC_TOL = 2,
    parameter int N_ADDR   = 4,
    parameter int AW       = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic [N_ADDR*AW-1:0] term_addr,
    input  logic [N_ADDR-1:0]    term_en,
    output logic                 irq_word,
    output logic                 irq_err,
    output logic [WORD_W-1:0]    rx_word,
    output logic                 rx_cmd_sync,
    output logic [1:0]           err_status,
    output logic                 addr_hit
);
    typedef struct packed {
        logic              irq_w;
        logic              irq_e;
        logic [WORD_W-1:0] word;
        logic              cmd;
        logic [1:0]        st;
        logic              hit;
    } top_reg_t;

    top_reg_t          t_q, t_d;
    logic              fin, fin_cmd, fin_code_err, fin_par_err, match;
    logic [WORD_W-1:0] fin_word;
    logic [1:0]        err_now;

    mbus_rx_core #(.SPB(SPB), .TOL(SYNC_TOL)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_in        (rx_in),
        .fin          (fin),
        .fin_word     (fin_word),
        .fin_cmd      (fin_cmd),
        .fin_code_err (fin_code_err),
        .fin_par_err  (fin_par_err)
    );

    mbus_addr_match #(.N_ADDR(N_ADDR), .AW(AW)) u_match (
        .field (fin_word[WORD_W-1 -: AW]),
        .cfg   (term_addr),
        .en    (term_en),
        .hit   (match)
    );

    always_comb begin
        t_d       = t_q;
        t_d.irq_w = 1'b0;
        t_d.irq_e = 1'b0;
        err_now            = '0;
        err_now[ERR_CODE]  = fin_code_err;
        err_now[ERR_PAR]   = fin_par_err;
        if (fin) begin
            t_d.word  = fin_word;
            t_d.cmd   = fin_cmd;
            t_d.st    = err_now;
            t_d.irq_w = (err_now == 2'b00);
            t_d.irq_e = (err_now != 2'b00);
            t_d.hit   = fin_cmd && (err_now == 2'b00) && match;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq_word    = t_q.irq_w;
    assign irq_err     = t_q.irq_e;
    assign rx_word     = t_q.word;
    assign rx_cmd_sync = t_q.cmd;
    assign err_status  = t_q.st;
    assign addr_hit    = t_q.hit;

    a_r12_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_word && irq_err));

    a_r7_word_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_word |=> !irq_word);

    a_r7_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_word |-> err_status == 2'b00);

    a_r8_err_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (err_status != 2'b00 && $past(!irq_err)));

    a_r11_hit_clean_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> (rx_cmd_sync && err_status == 2'b00));

    a_r10_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_word && rx_cmd_sync && rx_word[WORD_W-1 -: AW] == {AW{1'b1}}) |-> addr_hit);
endmodule

// File: tb/sim_mbus_word_rx.sv
module sim_mbus_word_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b0;
    logic [19:0] term_addr = '0;
    logic [3:0]  term_en = '0;
    logic        irq_word, irq_err, rx_cmd_sync, addr_hit;
    logic [15:0] rx_word;
    logic [1:0]  err_status;

    int checks = 0;
    int fails = 0;
    int n_w = 0;
    int n_e = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mbus_word_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .term_addr(term_addr), .term_en(term_en),
        .irq_word(irq_word), .irq_err(irq_err), .rx_word(rx_word),
        .rx_cmd_sync(rx_cmd_sync), .err_status(err_status), .addr_hit(addr_hit)
    );

    always @(posedge clk) begin
        if (rst_n && irq_word) n_w <= n_w + 1;
        if (rst_n && irq_err)  n_e <= n_e + 1;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic cmd, input logic bad, input logic [15:0] d,
                                     input logic [19:0] cfg, input logic [3:0] en);
        logic h;
        h = (d[15:11] == 5'd31);
        for (int i = 0; i < 4; i++)
            if (en[i] && cfg[i*5 +: 5] == d[15:11]) h = 1'b1;
        return cmd && !bad && h;
    endfunction

    task automatic drive(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_in = v;
        end
    endtask

    // bad_bit: cell index 0..15 driven without a mid-bit transition, -1 for none
    task automatic send(input logic cmd, input logic [15:0] d, input logic par_flip,
                        input int bad_bit, input int h1, input int h2, input logic expect_out);
        logic [16:0] cells;
        logic        bad;
        int          w0, e0;
        cells = {d, (~^d) ^ par_flip};
        w0 = n_w;
        e0 = n_e;
        drive(~cmd, 40);
        drive(cmd, h1);
        drive(~cmd, h2);
        for (int k = 16; k >= 0; k--) begin
            if ((16 - k) == bad_bit) drive(cells[k], 16);
            else begin
                drive(cells[k], 8);
                drive(~cells[k], 8);
            end
        end
        @(negedge clk);
        bad = (bad_bit >= 0) || par_flip;
        if (expect_out) begin
            check(bad ? "R8 err irq" : "R7 word irq", {30'd0, irq_word, irq_err},
                  bad ? 32'd1 : 32'd2);
            check("R4 data", {16'd0, rx_word}, {16'd0, d});
            check("R2 sync type", {31'd0, rx_cmd_sync}, {31'd0, cmd});
            check("R5 R6 status", {30'd0, err_status},
                  {30'd0, (bad_bit >= 0), par_flip});
            check("R9 R10 R11 hit", {31'd0, addr_hit},
                  {31'd0, exp_hit(cmd, bad, d, term_addr, term_en)});
            @(negedge clk);
            check("R12 single pulse", {30'd0, irq_word, irq_err}, 32'd0);
            check("R7 R8 one irq per word", n_w + n_e, w0 + e0 + 1);
        end else begin
            drive(~cmd, 60);
            check("R3 rejected header", n_w + n_e, w0 + e0);
        end
    endtask

    initial begin
        void'($urandom(32'd7731));
        repeat (4) @(negedge clk);
        check("R1 reset irqs", {30'd0, irq_word, irq_err}, 32'd0);
        check("R1 reset word", {16'd0, rx_word}, 32'd0);
        check("R1 reset flags", {29'd0, rx_cmd_sync, err_status}, 32'd0);
        check("R1 reset hit", {31'd0, addr_hit}, 32'd0);
        rst_n = 1'b1;

        term_addr = {5'd9, 5'd17, 5'd3, 5'd5};
        term_en   = 4'b0101;
        send(1'b1, {5'd5, 11'h2A5}, 1'b0, -1, 24, 24, 1'b1);  // R9 entry 0
        send(1'b1, {5'd17, 11'h0F1}, 1'b0, -1, 24, 24, 1'b1); // R9 entry 2
        send(1'b1, {5'd3, 11'h155}, 1'b0, -1, 24, 24, 1'b1);  // R11 disabled entry
        send(1'b0, {5'd5, 11'h7FF}, 1'b0, -1, 24, 24, 1'b1);  // R11 data sync
        term_en = 4'b0000;
        send(1'b1, 16'hFFFF, 1'b0, -1, 24, 24, 1'b1);         // R10 broadcast
        send(1'b1, 16'h0000, 1'b0, -1, 24, 24, 1'b1);
        term_en = 4'b1111;
        send(1'b1, {5'd9, 11'h001}, 1'b0, 3, 24, 24, 1'b1);   // R5 coding error
        send(1'b1, {5'd9, 11'h001}, 1'b1, -1, 24, 24, 1'b1);  // R6 parity error
        send(1'b0, 16'hC3A5, 1'b1, 15, 24, 24, 1'b1);         // R5 R6 both
        send(1'b1, 16'h1234, 1'b0, -1, 22, 24, 1'b1);         // R2 short edge
        send(1'b0, 16'hBEEF, 1'b0, -1, 26, 24, 1'b1);         // R2 long edge
        send(1'b1, 16'h5A5A, 1'b0, -1, 30, 30, 1'b0);         // R3 stretched
        send(1'b0, 16'h5A5A, 1'b0, -1, 20, 30, 1'b0);         // R3 shortened
        send(1'b1, 16'hA5A5, 1'b0, -1, 24, 24, 1'b1);         // recovery

        for (int n = 0; n < 60; n++) begin
            logic [15:0] d;
            int          bb;
            logic        pf;
            term_addr = $urandom();
            term_en   = $urandom();
            d  = $urandom();
            if ($urandom_range(0, 3) == 0) d[15:11] = term_addr[5*$urandom_range(0, 3) +: 5];
            bb = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 15) : -1;
            pf = ($urandom_range(0, 7) == 0);
            send($urandom_range(0, 1), d, pf, bb, $urandom_range(22, 26), 24, 1'b1);
        end
        finish_run();
    end
endmodule